// File: doc/BRIEF.md
# CAN Error Counter and Fault Confinement Unit

This unit keeps the two error counters of a CAN node and decides whether the node is error-active, error-passive or bus-off. The protocol engine sends it one-cycle strobes. These report a transmit error, a receive error, a successful transmission and a successful reception. An error strobe also carries the class of the error and a 5-bit location code. From the counter values the unit derives a warning status against a programmable limit, a passive status and a bus-off status. It raises a one-cycle interrupt pulse whenever the warning or bus-off status changes, and another whenever the passive status changes.

The unit also keeps a record of the most recent bus error: its class, whether the node was sending or receiving, and where in the frame it happened. The record stays locked until it is read, so a later error cannot overwrite a record that has not been read. Software uses a small register port to program the warning limit and to read or preset the counters. Writes take effect only while the controller is held in its configuration (reset) mode. Protocol events are ignored in that mode.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters read 0, the warning limit reads 96, and every status, interrupt and capture-valid output is 0.
- R2: A transmit error adds 8 to the transmit counter. A successful transmission subtracts 1, and the counter never goes below 0. When both strobes arrive in the same cycle, the error wins.
- R3: A receive error adds 1 to the receive counter and saturates at 255. A successful reception subtracts 1, and the counter never goes below 0.
- R4: While listen_only is 1, receive errors and successful receptions leave the receive counter unchanged.
- R5: st_warn is 1 exactly when either counter is greater than or equal to the programmed warning limit.
- R6: irq_warn is a one-cycle pulse in the cycle after st_warn or st_busoff changes, in either direction.
- R7: st_passive is 1 when either counter exceeds 127. irq_passive pulses for one cycle after each change of st_passive.
- R8: A transmit error that would take the transmit counter above 255 sets st_busoff and leaves the counter at 255; 247 plus 8 gives 255 and does not set it. While bus-off, all event strobes are ignored. A register write of the transmit counter clears bus-off.
- R9: An error strobe accepted while no record is held stores an 8-bit word: class in bits 7:6 (00 bit, 01 form, 10 stuff, 11 other), direction in bit 5 (1 receive, 0 transmit; transmit wins when both strobes arrive together) and the location in bits 4:0. cap_valid is then set.
- R10: While cap_valid is 1, new errors leave the stored word unchanged. A read of the capture (reg_rd with select 3) clears cap_valid, and a later error is stored again.
- R11: While cfg_hold is 1, event strobes have no effect on the counters or the capture. Register writes take effect only while cfg_hold is 1.
- R12: Register select codes: 0 warning limit, 1 receive counter, 2 transmit counter, 3 capture word (read only). reg_rdata follows reg_sel combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hold | input | 1 | Controller held in configuration mode |
| listen_only | input | 1 | Receive counter frozen when 1 |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_rx_err | input | 1 | Receive error strobe |
| ev_tx_ok | input | 1 | Successful transmission strobe |
| ev_rx_ok | input | 1 | Successful reception strobe |
| ev_kind | input | 2 | Error class for an error strobe |
| ev_seg | input | 5 | Error location code for an error strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the capture when select is 3) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| st_warn | output | 1 | A counter is at or above the warning limit |
| st_passive | output | 1 | A counter is above 127 |
| st_busoff | output | 1 | Node is bus-off |
| cap_valid | output | 1 | Capture word holds an unread error |
| irq_warn | output | 1 | Warning or bus-off change pulse |
| irq_passive | output | 1 | Passive change pulse |

## Verification
The assertions assume that the engine's strobes last one cycle each. They also assume that reg_wr and reg_rd are never asserted together with a strobe the unit is expected to act on. The bench drives every strobe and register access for exactly one cycle, changing inputs only on the falling edge, so this holds. Counter presets are written only with cfg_hold raised, and the bench then waits one idle cycle before sending events. Each edge pulse is therefore caused by a single, known event.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int CNT_W   = 8;
  localparam int KIND_W  = 2;
  localparam int SEG_W   = 5;
  localparam int SEL_W   = 2;
  localparam int CAP_W   = KIND_W + 1 + SEG_W;
  localparam int RD_W    = (CNT_W > CAP_W) ? CNT_W : CAP_W;
  localparam int WARN_RST = 96;
  localparam int TX_STEP  = 8;
  localparam int RX_STEP  = 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [KIND_W-1:0] {
    KIND_BIT   = 2'b00,
    KIND_FORM  = 2'b01,
    KIND_STUFF = 2'b10,
    KIND_OTHER = 2'b11
  } err_kind_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_LIMIT   = 2'd0,
    SEL_RXCNT   = 2'd1,
    SEL_TXCNT   = 2'd2,
    SEL_CAPTURE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    err_kind_e        kind;
    logic             dir_rx;
    logic [SEG_W-1:0] seg;
  } cap_t;

  typedef struct packed {
    logic ovf;
    cnt_t val;
  } step_t;

  // One counter update: an error adds inc (saturating, overflow flagged),
  // a success subtracts one down to zero, an error beats a success.
  function automatic step_t cnt_step(input cnt_t c, input cnt_t inc,
                                     input logic err, input logic ok);
    step_t r;
    logic [CNT_W:0] sum;
    sum   = {1'b0, c} + {1'b0, inc};
    r.ovf = 1'b0;
    r.val = c;
    if (err) begin
      r.ovf = sum[CNT_W];
      r.val = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end else if (ok) begin
      r.val = (c == '0) ? c : c - 1'b1;
    end
    return r;
  endfunction

  function automatic logic reaches(input cnt_t c, input cnt_t lim);
    return c >= lim;
  endfunction

  function automatic logic above_half(input cnt_t c);
    return c[CNT_W-1];
  endfunction
endpackage

// File: rtl/can_fc_errcnt.sv
module can_fc_errcnt
  import can_fc_pkg::*;
#(
  parameter int INC      = 1,
  parameter bit GOES_OFF = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic err,
  input  logic ok,
  input  logic wr,
  input  cnt_t wdata,
  output cnt_t cnt,
  output logic off
);
  localparam cnt_t INC_C = cnt_t'(INC);
  localparam cnt_t MAXV  = '1;

  step_t nxt;
  logic  step_ovf;

  always_comb nxt = cnt_step(cnt, INC_C, err, ok);
  assign step_ovf = en & nxt.ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (en)  cnt <= nxt.val;
  end

  generate
    if (GOES_OFF) begin : g_off
      logic off_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        off_q <= 1'b0;
        else if (wr)       off_q <= 1'b0;
        else if (step_ovf) off_q <= 1'b1;
      end
      assign off = off_q;
    end else begin : g_no_off
      assign off = 1'b0;
    end
  endgenerate

  // R2 / R3: an accepted error adds the lane's step when there is room
  p_err_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr && err && cnt <= MAXV - INC_C) |=> cnt == cnt_t'($past(cnt) + INC_C));

  // R3: success at zero stays at zero
  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr && ok && !err && cnt == '0) |=> cnt == '0);

  // R11: no enable and no write means no change
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr) |=> $stable(cnt));
endmodule

// File: rtl/can_fc_status.sv
module can_fc_status
  import can_fc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t tx_cnt,
  input  cnt_t rx_cnt,
  input  cnt_t limit,
  input  logic busoff,
  output logic st_warn,
  output logic st_passive,
  output logic irq_warn,
  output logic irq_passive
);
  logic warn_q, off_q, pas_q;

  assign st_warn    = reaches(tx_cnt, limit) | reaches(rx_cnt, limit);
  assign st_passive = above_half(tx_cnt) | above_half(rx_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      off_q  <= 1'b0;
      pas_q  <= 1'b0;
    end else begin
      warn_q <= st_warn;
      off_q  <= busoff;
      pas_q  <= st_passive;
    end
  end

  assign irq_warn    = (st_warn ^ warn_q) | (busoff ^ off_q);
  assign irq_passive = st_passive ^ pas_q;

  // R6: every edge of warning or bus-off status is reported
  p_warn_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_warn) || $fell(st_warn) || $rose(busoff) || $fell(busoff)) |-> irq_warn);

  // R7: every edge of passive status is reported
  p_pass_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_passive) || $fell(st_passive)) |-> irq_passive);
endmodule

// File: rtl/can_fc_capture.sv
module can_fc_capture
  import can_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tx_err,
  input  logic              rx_err,
  input  logic [KIND_W-1:0] kind,
  input  logic [SEG_W-1:0]  seg,
  input  logic              rd_clr,
  output logic [CAP_W-1:0]  cap_word,
  output logic              cap_valid
);
  logic cap_ev;
  cap_t fresh;

  assign cap_ev       = active & (tx_err | rx_err);
  assign fresh.kind   = err_kind_e'(kind);
  assign fresh.dir_rx = ~tx_err;
  assign fresh.seg    = seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word  <= '0;
      cap_valid <= 1'b0;
    end else if (cap_ev && (!cap_valid || rd_clr)) begin
      cap_word  <= fresh;
      cap_valid <= 1'b1;
    end else if (rd_clr) begin
      cap_valid <= 1'b0;
    end
  end

  // R10: an unread record is frozen
  p_cap_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !rd_clr) |=> cap_valid && $stable(cap_word));

  // R9: an accepted error with an empty slot produces a record
  p_cap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && !cap_valid) |=> cap_valid);
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hold,
  input  logic              listen_only,
  input  logic              ev_tx_err,
  input  logic              ev_rx_err,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_ok,
  input  logic [KIND_W-1:0] ev_kind,
  input  logic [SEG_W-1:0]  ev_seg,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              st_warn,
  output logic              st_passive,
  output logic              st_busoff,
  output logic              cap_valid,
  output logic              irq_warn,
  output logic              irq_passive
);
  logic active, tx_en, rx_en, wr_ok, rd_clr, rx_off;
  cnt_t tx_cnt, rx_cnt, limit_q;
  logic [CAP_W-1:0] cap_word;

  assign active = ~cfg_hold & ~st_busoff;
  assign tx_en  = active;
  assign rx_en  = active & ~listen_only;
  assign wr_ok  = reg_wr & cfg_hold;
  assign rd_clr = reg_rd & (reg_sel == SEL_CAPTURE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                limit_q <= cnt_t'(WARN_RST);
    else if (wr_ok && reg_sel == SEL_LIMIT)    limit_q <= reg_wdata;
  end

  can_fc_errcnt #(.INC(TX_STEP), .GOES_OFF(1'b1)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .err(ev_tx_err), .ok(ev_tx_ok),
    .wr(wr_ok && reg_sel == SEL_TXCNT), .wdata(reg_wdata),
    .cnt(tx_cnt), .off(st_busoff)
  );

  can_fc_errcnt #(.INC(RX_STEP), .GOES_OFF(1'b0)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .err(ev_rx_err), .ok(ev_rx_ok),
    .wr(wr_ok && reg_sel == SEL_RXCNT), .wdata(reg_wdata),
    .cnt(rx_cnt), .off(rx_off)
  );

  can_fc_status u_status (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .limit(limit_q), .busoff(st_busoff),
    .st_warn(st_warn), .st_passive(st_passive),
    .irq_warn(irq_warn), .irq_passive(irq_passive)
  );

  can_fc_capture u_capture (
    .clk(clk), .rst_n(rst_n), .active(active),
    .tx_err(ev_tx_err), .rx_err(ev_rx_err), .kind(ev_kind), .seg(ev_seg),
    .rd_clr(rd_clr), .cap_word(cap_word), .cap_valid(cap_valid)
  );

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_LIMIT:   reg_rdata = RD_W'(limit_q);
      SEL_RXCNT:   reg_rdata = RD_W'(rx_cnt);
      SEL_TXCNT:   reg_rdata = RD_W'(tx_cnt);
      default:     reg_rdata = RD_W'(cap_word);
    endcase
  end

  // R8: bus-off pins the transmit counter at full scale and freezes it
  p_busoff_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_busoff |-> tx_cnt == '1);
  p_busoff_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busoff && !reg_wr) |=> $stable(tx_cnt));

  // R4: listen-only keeps the receive counter frozen
  p_listen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (listen_only && !reg_wr) |=> $stable(rx_cnt));

  // R3: the receive lane saturates and never signals bus-off
  p_rx_no_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_off);
endmodule

// File: tb/can_fault_confine_test.sv
`timescale 1ns/1ps
module can_fault_confine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_hold = 1'b0, listen_only = 1'b0;
  logic ev_tx_err = 1'b0, ev_rx_err = 1'b0, ev_tx_ok = 1'b0, ev_rx_ok = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [4:0] ev_seg = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic st_warn, st_passive, st_busoff, cap_valid, irq_warn, irq_passive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_fault_confine uut (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .listen_only(listen_only),
    .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
    .ev_kind(ev_kind), .ev_seg(ev_seg), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_warn(st_warn), .st_passive(st_passive), .st_busoff(st_busoff),
    .cap_valid(cap_valid), .irq_warn(irq_warn), .irq_passive(irq_passive)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_hold = 1'b0; listen_only = 1'b0;
    {ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ev(input logic te, input logic re, input logic to, input logic ro,
                    input logic [1:0] k, input logic [4:0] s);
    ev_tx_err = te; ev_rx_err = re; ev_tx_ok = to; ev_rx_ok = ro;
    ev_kind = k; ev_seg = s;
    @(negedge clk);
    {ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic preset(input logic [1:0] sel, input logic [7:0] d);
    cfg_hold = 1'b1;
    wr_reg(sel, d);
    cfg_hold = 1'b0;
    idle();
  endtask

  task automatic rd_reg(input logic [1:0] sel, output int v);
    reg_sel = sel;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd_reg(2'd0, v); check("R1 limit", v, 96);
    rd_reg(2'd1, v); check("R1 rx cnt", v, 0);
    rd_reg(2'd2, v); check("R1 tx cnt", v, 0);
    rd_reg(2'd3, v); check("R12 capture word", v, 0);
    check("R1 status", {st_warn, st_passive, st_busoff, cap_valid, irq_warn, irq_passive}, 0);
  endtask

  task automatic t_tx_count();
    int v;
    do_reset();
    for (int i = 0; i < 11; i++) ev(1, 0, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R2 tx +8 x11", v, 88);
    check("R5 warn below limit", st_warn, 0);
    ev(1, 0, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R2 tx 96", v, 96);
    check("R5 warn at limit", st_warn, 1);
    check("R6 irq on rise", irq_warn, 1);
    idle();
    check("R6 irq one cycle", irq_warn, 0);
    ev(1, 0, 1, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R2 error beats success", v, 104);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R2 tx down to 95", v, 95);
    check("R5 warn fell", st_warn, 0);
    check("R6 irq on fall", irq_warn, 1);
    preset(2'd2, 8'd1);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R2 floor at zero", v, 0);
  endtask

  task automatic t_passive();
    int v;
    do_reset();
    preset(2'd2, 8'd120);
    ev(1, 0, 0, 0, 2'd0, 5'd0);
    check("R7 passive at 128", st_passive, 1);
    check("R7 irq on enter", irq_passive, 1);
    idle();
    check("R7 irq one cycle", irq_passive, 0);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R7 tx 127", v, 127);
    check("R7 active at 127", st_passive, 0);
    check("R7 irq on leave", irq_passive, 1);
  endtask

  task automatic t_busoff();
    int v;
    do_reset();
    preset(2'd2, 8'd247);
    ev(1, 0, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R8 247+8", v, 255);
    check("R8 not off at 255", st_busoff, 0);
    do_reset();
    preset(2'd2, 8'd248);
    ev(1, 0, 0, 0, 2'd0, 5'd0);
    check("R8 off on overflow", st_busoff, 1);
    rd_reg(2'd2, v); check("R8 tx pinned", v, 255);
    check("R6 irq on bus-off", irq_warn, 1);
    ev(0, 0, 1, 0, 2'd0, 5'd0);
    ev(0, 1, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd2, v); check("R8 tx frozen", v, 255);
    rd_reg(2'd1, v); check("R8 rx frozen", v, 0);
    cfg_hold = 1'b1;
    wr_reg(2'd2, 8'd0);
    check("R8 write clears off", st_busoff, 0);
    check("R6 irq on leave bus-off", irq_warn, 1);
    cfg_hold = 1'b0;
  endtask

  task automatic t_rx();
    int v;
    do_reset();
    ev(0, 1, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd1, v); check("R3 rx +1", v, 1);
    ev(0, 0, 0, 1, 2'd0, 5'd0);
    ev(0, 0, 0, 1, 2'd0, 5'd0);
    rd_reg(2'd1, v); check("R3 rx floor", v, 0);
    preset(2'd1, 8'd5);
    listen_only = 1'b1;
    ev(0, 1, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd1, v); check("R4 error ignored", v, 5);
    ev(0, 0, 0, 1, 2'd0, 5'd0);
    rd_reg(2'd1, v); check("R4 success ignored", v, 5);
    listen_only = 1'b0;
    ev(0, 0, 0, 1, 2'd0, 5'd0);
    rd_reg(2'd1, v); check("R3 rx -1", v, 4);
    preset(2'd1, 8'd255);
    ev(0, 1, 0, 0, 2'd0, 5'd0);
    rd_reg(2'd1, v); check("R3 rx saturate", v, 255);
    check("R3 no bus-off from rx", st_busoff, 0);
  endtask

  task automatic t_limit_hold();
    int v;
    do_reset();
    preset(2'd0, 8'd2);
    rd_reg(2'd0, v); check("R12 limit readback", v, 2);
    ev(0, 1, 0, 0, 2'd0, 5'd0);
    check("R5 rx 1 below 2", st_warn, 0);
    ev(0, 1, 0, 0, 2'd0, 5'd0);
    check("R5 rx 2 at 2", st_warn, 1);
    do_reset();
    cfg_hold = 1'b1;
    ev(1, 1, 0, 0, 2'd1, 5'd4);
    rd_reg(2'd2, v); check("R11 tx held", v, 0);
    rd_reg(2'd1, v); check("R11 rx held", v, 0);
    check("R11 no capture in hold", cap_valid, 0);
    cfg_hold = 1'b0;
    wr_reg(2'd0, 8'd5);
    rd_reg(2'd0, v); check("R11 write outside hold ignored", v, 96);
  endtask

  task automatic t_capture();
    int v;
    do_reset();
    ev(1, 0, 0, 0, 2'd2, 5'd10);
    check("R9 valid set", cap_valid, 1);
    rd_reg(2'd3, v); check("R9 tx stuff word", v, 8'h8A);
    ev(0, 1, 0, 0, 2'd1, 5'd3);
    rd_reg(2'd3, v); check("R10 not overwritten", v, 8'h8A);
    reg_sel = 2'd3; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R10 read clears valid", cap_valid, 0);
    ev(0, 1, 0, 0, 2'd1, 5'd3);
    rd_reg(2'd3, v); check("R9 rx form word", v, 8'h63);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    ev(1, 1, 0, 0, 2'd3, 5'd31);
    rd_reg(2'd3, v); check("R9 tx wins direction", v, 8'hDF);
  endtask

  initial begin
    t_reset();
    t_tx_count();
    t_passive();
    t_busoff();
    t_rx();
    t_limit_hold();
    t_capture();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule